// File: doc/BRIEF.md
# Overlay Memory Map Decoder

This block turns a 16-bit processor address into a chip select for one of four targets: main RAM, a language ROM, a system ROM or an I/O block. Three regions of the 64K space can be switched. Low configuration bits decide whether each region shows ROM, I/O or the RAM that lies beneath it. The decode is purely combinational. It looks only at the address, the write strobe and the configuration byte, so the selects follow the inputs within the same bus cycle.

Writes into a ROM window always land in the RAM underneath. Software can therefore fill that RAM while the ROM is still visible for reads, and then switch the ROM out. When both ROM enables are clear, the processor sees a flat 64K of RAM, and the I/O window is gone as well. The configuration byte is wider than the three control bits. The remaining bits, including a switch-sense bit at position 4, carry no memory-control meaning.

Top module: `ovl_map_decoder`

## Requirements
- R1: Addresses 0x0000–0x9FFF and 0xC000–0xCFFF select RAM for reads and writes under every configuration.
- R2: A read in 0xA000–0xBFFF selects the language ROM when cfg[0] is 1 and selects RAM when cfg[0] is 0.
- R3: A read in 0xE000–0xFFFF selects the system ROM when cfg[1] is 1 and selects RAM when cfg[1] is 0.
- R4: Reads and writes in 0xD000–0xDFFF select the I/O block when cfg[2] is 1 and cfg[1:0] is not 00. Otherwise that range selects RAM.
- R5: When cfg[1:0] is 00, every address selects RAM for both reads and writes, whatever the value of cfg[2].
- R6: A write (wr_en = 1) never selects either ROM. A write into an enabled ROM window selects RAM.
- R7: Exactly one of sel_ram, sel_lrom, sel_srom and sel_io is 1 for every input combination.
- R8: cfg[7:3], including the switch-sense bit cfg[4], has no effect on any select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor bus address |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle |
| cfg | input | 8 | Configuration byte; bit 0 language ROM, bit 1 system ROM, bit 2 I/O window |
| sel_ram | output | 1 | Chip select for main RAM |
| sel_lrom | output | 1 | Chip select for the language ROM |
| sel_srom | output | 1 | Chip select for the system ROM |
| sel_io | output | 1 | Chip select for the I/O block |

## Verification
The bench probes the first and last byte of each switchable window, along with the bytes just outside each window. This separates a correct region boundary from one that is off by a page. Every window is tried with each ROM enable set alone and with both set, under both read and write. These cases show whether the language and system enables are swapped, and whether writes fall through to RAM. The configurations 000 and 100 tell the all-RAM rule apart from a plain I/O-enable decode. A sweep of all eight control values across every 4K page, for reads and writes, confirms that exactly one select is active. Repeating key cases with the upper configuration bits set shows that those bits are ignored.

// File: rtl/ovl_map_pkg.sv
package ovl_map_pkg;

    // Which switchable window an address falls in
    typedef enum logic [1:0] {
        RG_PLAIN = 2'd0,
        RG_LANG  = 2'd1,
        RG_IO    = 2'd2,
        RG_SYS   = 2'd3
    } region_e;

    // Which device gets the bus cycle
    typedef enum logic [1:0] {
        TG_RAM  = 2'd0,
        TG_LROM = 2'd1,
        TG_SROM = 2'd2,
        TG_IO   = 2'd3
    } target_e;

    localparam int NUM_TARGETS = 4;

    // Decoded overlay enables
    typedef struct packed {
        logic lang_on;
        logic sys_on;
        logic io_on;
    } overlay_t;

    // Chip-select vector, bit index matches target_e value
    typedef logic [NUM_TARGETS-1:0] csel_t;

    // Route one bus cycle given its window, enables and direction
    function automatic target_e route(input region_e rg, input overlay_t ov, input logic wr);
        target_e t;
        t = TG_RAM;
        unique case (rg)
            RG_LANG: if (ov.lang_on && !wr) t = TG_LROM;
            RG_SYS:  if (ov.sys_on  && !wr) t = TG_SROM;
            RG_IO:   if (ov.io_on)          t = TG_IO;
            default: t = TG_RAM;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ovl_region_classify.sv
module ovl_region_classify
    import ovl_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter logic [PAGE_W-1:0] LANG_FIRST = 4'hA,
    parameter logic [PAGE_W-1:0] LANG_LAST  = 4'hB,
    parameter logic [PAGE_W-1:0] IO_PAGE    = 4'hD,
    parameter logic [PAGE_W-1:0] SYS_FIRST  = 4'hE,
    parameter logic [PAGE_W-1:0] SYS_LAST   = 4'hF
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int PAGE_LSB = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic [PAGE_LSB-1:0] unused_offset;

    assign page          = addr[ADDR_W-1:PAGE_LSB];
    assign unused_offset = addr[PAGE_LSB-1:0];

    always_comb begin
        if (page >= LANG_FIRST && page <= LANG_LAST)
            region = RG_LANG;
        else if (page >= SYS_FIRST && page <= SYS_LAST)
            region = RG_SYS;
        else if (page == IO_PAGE)
            region = RG_IO;
        else
            region = RG_PLAIN;
    end
endmodule

// File: rtl/ovl_cfg_decode.sv
module ovl_cfg_decode
    import ovl_map_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int LANG_BIT = 0,
    parameter int SYS_BIT  = 1,
    parameter int IO_BIT   = 2
) (
    input  logic [CFG_W-1:0] cfg,
    output overlay_t         ov
);
    logic any_rom;

    // With both ROM enables clear the map is flat RAM, I/O included
    assign any_rom    = cfg[LANG_BIT] | cfg[SYS_BIT];
    assign ov.lang_on = cfg[LANG_BIT];
    assign ov.sys_on  = cfg[SYS_BIT];
    assign ov.io_on   = any_rom & cfg[IO_BIT];
endmodule

// File: rtl/ovl_select.sv
module ovl_select
    import ovl_map_pkg::*;
(
    input  region_e  region,
    input  overlay_t ov,
    input  logic     wr_en,
    output csel_t    csel
);
    target_e tgt;

    assign tgt = route(region, ov, wr_en);

    for (genvar i = 0; i < NUM_TARGETS; i++) begin : g_onehot
        assign csel[i] = (tgt == target_e'(i));
    end
endmodule

// File: rtl/ovl_map_decoder.sv
module ovl_map_decoder
    import ovl_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CFG_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  cfg,
    output logic              sel_ram,
    output logic              sel_lrom,
    output logic              sel_srom,
    output logic              sel_io
);
    localparam int CTRL_BITS = 3;

    region_e  region;
    overlay_t ov;
    csel_t    csel;
    logic     unused_cfg_hi;

    // Upper configuration bits (switch sense etc.) are not memory controls
    assign unused_cfg_hi = ^cfg[CFG_W-1:CTRL_BITS];

    ovl_region_classify #(.ADDR_W(ADDR_W)) u_region (
        .addr   (addr),
        .region (region)
    );

    ovl_cfg_decode #(.CFG_W(CFG_W)) u_cfg (
        .cfg (cfg),
        .ov  (ov)
    );

    ovl_select u_sel (
        .region (region),
        .ov     (ov),
        .wr_en  (wr_en),
        .csel   (csel)
    );

    assign sel_ram  = csel[TG_RAM];
    assign sel_lrom = csel[TG_LROM];
    assign sel_srom = csel[TG_SROM];
    assign sel_io   = csel[TG_IO];
endmodule

// File: rtl/ovl_map_decoder_chk.sv
module ovl_map_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int CFG_W  = 8
) (
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [CFG_W-1:0]  cfg,
    input logic              sel_ram,
    input logic              sel_lrom,
    input logic              sel_srom,
    input logic              sel_io
);
    logic [3:0] pg;
    logic [3:0] sels;
    logic       fixed_area;

    assign pg         = addr[ADDR_W-1 -: 4];
    assign sels       = {sel_io, sel_srom, sel_lrom, sel_ram};
    assign fixed_area = (pg < 4'hA) || (pg == 4'hC);

    always_comb begin
        if (!$isunknown({addr, wr_en, cfg})) begin
            AST_ONE_SELECT: assert ($countones(sels) == 1) else $error("select count %0d", $countones(sels)); // R7
            AST_FIXED_RAM: assert (!fixed_area || sel_ram) else $error("fixed area not RAM"); // R1
            AST_LANG_WINDOW: assert (!sel_lrom || (cfg[0] && (pg == 4'hA || pg == 4'hB))) else $error("lang ROM outside window"); // R2
            AST_SYS_WINDOW: assert (!sel_srom || (cfg[1] && pg >= 4'hE)) else $error("sys ROM outside window"); // R3
            AST_IO_WINDOW: assert (!sel_io || (pg == 4'hD && cfg[2])) else $error("I/O outside window"); // R4
            AST_FLAT_RAM: assert (cfg[1:0] != 2'b00 || sel_ram) else $error("flat map not RAM"); // R5
            AST_WRITE_NO_ROM: assert (!wr_en || (!sel_lrom && !sel_srom)) else $error("write hit ROM"); // R6
        end
    end
endmodule

bind ovl_map_decoder ovl_map_decoder_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_chk (
    .addr     (addr),
    .wr_en    (wr_en),
    .cfg      (cfg),
    .sel_ram  (sel_ram),
    .sel_lrom (sel_lrom),
    .sel_srom (sel_srom),
    .sel_io   (sel_io)
);

// File: tb/ovl_map_decoder_test.sv
`timescale 1ns/1ps
module ovl_map_decoder_test;
    // Expected select codes: {io, srom, lrom, ram}
    localparam logic [3:0] E_RAM  = 4'b0001;
    localparam logic [3:0] E_LROM = 4'b0010;
    localparam logic [3:0] E_SROM = 4'b0100;
    localparam logic [3:0] E_IO   = 4'b1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  cfg = 8'h07;
    logic        sel_ram, sel_lrom, sel_srom, sel_io;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    ovl_map_decoder uut (
        .addr     (addr),
        .wr_en    (wr_en),
        .cfg      (cfg),
        .sel_ram  (sel_ram),
        .sel_lrom (sel_lrom),
        .sel_srom (sel_srom),
        .sel_io   (sel_io)
    );

    task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] c);
        @(negedge clk);
        addr  = a;
        wr_en = w;
        cfg   = c;
        #2;
    endtask

    task automatic expect_sel(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {sel_io, sel_srom, sel_lrom, sel_ram};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0d cfg=%h actual=%b expected=%b",
                     req, addr, wr_en, cfg, got, exp);
        end
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic w,
                         input logic [7:0] c, input logic [3:0] exp);
        drive(a, w, c);
        expect_sel(req, exp);
    endtask

    task automatic t_reset_state;
        // idle bus just after bench reset: address 0 read with default config
        expect_sel("R1 reset", E_RAM);
    endtask

    task automatic t_fixed_ram; // R1
        logic [15:0] pts [6] = '{16'h0000, 16'h0001, 16'h9FFF, 16'hC000, 16'hCFFF, 16'h5A5A};
        logic [7:0]  cs  [3] = '{8'h07, 8'h00, 8'h05};
        foreach (cs[j]) foreach (pts[i]) begin
            probe("R1", pts[i], 1'b0, cs[j], E_RAM);
            probe("R1", pts[i], 1'b1, cs[j], E_RAM);
        end
    endtask

    task automatic t_lang_window; // R2
        probe("R2", 16'hA000, 1'b0, 8'h01, E_LROM);
        probe("R2", 16'hBFFF, 1'b0, 8'h01, E_LROM);
        probe("R2", 16'hA000, 1'b0, 8'h02, E_RAM);
        probe("R2", 16'hBFFF, 1'b0, 8'h06, E_RAM);
        probe("R2", 16'h9FFF, 1'b0, 8'h01, E_RAM);
        probe("R2", 16'hC000, 1'b0, 8'h01, E_RAM);
    endtask

    task automatic t_sys_window; // R3
        probe("R3", 16'hE000, 1'b0, 8'h02, E_SROM);
        probe("R3", 16'hFFFF, 1'b0, 8'h03, E_SROM);
        probe("R3", 16'hE000, 1'b0, 8'h01, E_RAM);
        probe("R3", 16'hFFFC, 1'b0, 8'h05, E_RAM);
        probe("R3", 16'hDFFF, 1'b0, 8'h02, E_RAM);
    endtask

    task automatic t_io_window; // R4
        probe("R4", 16'hD000, 1'b0, 8'h07, E_IO);
        probe("R4", 16'hDFFF, 1'b1, 8'h07, E_IO);
        probe("R4", 16'hD400, 1'b0, 8'h05, E_IO);
        probe("R4", 16'hD400, 1'b1, 8'h06, E_IO);
        probe("R4", 16'hD000, 1'b0, 8'h03, E_RAM);
        probe("R4", 16'hD800, 1'b1, 8'h03, E_RAM);
    endtask

    task automatic t_flat_ram; // R5
        logic [15:0] pts [5] = '{16'hA000, 16'hBFFF, 16'hD000, 16'hD800, 16'hE000};
        foreach (pts[i]) begin
            probe("R5", pts[i], 1'b0, 8'h00, E_RAM);
            probe("R5", pts[i], 1'b0, 8'h04, E_RAM);
            probe("R5", pts[i], 1'b1, 8'h04, E_RAM);
        end
    endtask

    task automatic t_write_through; // R6
        probe("R6", 16'hA123, 1'b1, 8'h07, E_RAM);
        probe("R6", 16'hF000, 1'b1, 8'h07, E_RAM);
        probe("R6", 16'hBFFF, 1'b1, 8'h01, E_RAM);
        probe("R6", 16'hFFFF, 1'b1, 8'h02, E_RAM);
        // same addresses read back as ROM once the write ends
        probe("R6", 16'hA123, 1'b0, 8'h07, E_LROM);
        probe("R6", 16'hF000, 1'b0, 8'h07, E_SROM);
    endtask

    task automatic t_one_hot_sweep; // R7
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 16; p++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [3:0] got;
                    drive({p[3:0], 12'h3C5}, w[0], c[7:0]);
                    got = {sel_io, sel_srom, sel_lrom, sel_ram};
                    n_chk++;
                    if ($countones(got) != 1) begin
                        n_fail++;
                        $display("FAIL R7 addr=%h wr=%0d cfg=%h actual=%b expected=one-hot",
                                 addr, wr_en, cfg, got);
                    end
                end
            end
        end
    endtask

    task automatic t_upper_bits; // R8
        probe("R8", 16'hA000, 1'b0, 8'h17, E_LROM);
        probe("R8", 16'hD000, 1'b0, 8'hF7, E_IO);
        probe("R8", 16'hE000, 1'b0, 8'h10, E_RAM);
        probe("R8", 16'hD000, 1'b0, 8'hF8, E_RAM);
        probe("R8", 16'hFFFF, 1'b0, 8'hEA, E_SROM);
        probe("R8", 16'hB000, 1'b0, 8'hE9, E_LROM);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        addr = 16'h0000; wr_en = 1'b0; cfg = 8'h07;
        #2;
        t_reset_state();
        t_fixed_ram();
        t_lang_window();
        t_sys_window();
        t_io_window();
        t_flat_ram();
        t_write_through();
        t_one_hot_sweep();
        t_upper_bits();
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog expired actual=running expected=done");
            finish_up();
        end
    end
endmodule